// File: doc/BRIEF.md
# Comma-Aligned Byte Framer

This block turns a serial line, one bit per clock, into 10-bit symbols and keeps the symbol boundary locked to the comma character of the line code. Every bit enters a 10-bit shifter, and the shifter is compared against both running-disparity forms of the K28.5 comma after each bit. A free-running bit counter marks the symbol boundary and presents the shifter contents on a byte strobe. When a comma is accepted, the counter is restarted so that the comma itself lands on a symbol boundary, and a reframe pulse is raised.

A reframe-enable input decides whether realignment may happen at all. While it is low, the block keeps deserializing on whatever boundary it already has. On a rising edge of the enable, the ready flag is held low until a comma has been accepted. If the enable stays high for a long run of symbols, the block moves to a stricter mode. In that mode a reframe needs two commas at the same bit phase within a short window of symbols, which makes a false lock on a comma image made by bit errors much less likely. Decoding of the 10-bit symbols lies outside this block.

Top module: `comma_framer`

## Requirements
- R1: Bits enter the shifter one per clock. The first received bit of a symbol ends up in word_out[9]. Without a reframe, byte_strobe rises once every 10 clocks, and word_out changes only in a cycle where byte_strobe is high.
- R2: The comma codes are 10'b0011111010 and 10'b1100000101, both with word_out[9] as the first bit. With reframe_en high in single-comma mode, a comma whose last bit is sampled at clock edge N raises both reframe_pulse and byte_strobe after edge N+1, with word_out equal to that comma. The next byte_strobe comes 10 clocks later.
- R3: While reframe_en is low, a comma produces no reframe_pulse, and byte_strobe keeps its existing spacing.
- R4: After reframe_en rises, ready stays low on every byte_strobe until a comma is accepted. ready is high on the strobe that carries the accepted comma.
- R5: When ready is not being held by R4, it is high on every byte_strobe. It is never high without byte_strobe.
- R6: A run counter counts byte strobes while reframe_en is high. The block switches to double-comma mode only after more than RUN_LIMIT (default 2048) strobes. Before that, a single comma still reframes.
- R7: In double-comma mode, a single comma does not reframe. A second comma at the same bit phase, whose last bit comes 10*k clocks after the first with k no greater than WIN_BYTES (default 5), reframes one clock after its last bit.
- R8: In double-comma mode, a same-phase comma that arrives later than WIN_BYTES symbols after the first does not reframe. It opens a fresh window instead.
- R9: In double-comma mode, a comma at a different bit phase inside an open window does not reframe. It restarts the window at its own phase, so a later same-phase comma within the window reframes.
- R10: Dropping reframe_en clears the run counter, so the block returns to single-comma mode.
- R11: During reset, byte_strobe, ready, reframe_pulse and word_out are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ser_in | input | 1 | Serial data bit, sampled on each rising clock edge |
| reframe_en | input | 1 | Permits realignment on commas |
| byte_strobe | output | 1 | One-cycle pulse marking a new symbol on word_out |
| word_out | output | 10 | Last aligned 10-bit symbol, first bit in bit 9 |
| ready | output | 1 | Symbol on this strobe is valid |
| reframe_pulse | output | 1 | One-cycle pulse when an accepted comma realigns the boundary |

## Verification
The bench places commas of both polarities at several bit offsets and measures the exact clock of the reframe pulse and of the strobe that follows it. An off-by-one in the bit counter or a missing reset of the counter shows up as a shifted or misaligned symbol. It toggles the enable to confirm that a design ignoring it would reframe, and that one without the ready hold would flag unaligned symbols as valid. It then runs past the long-run limit and probes the double-comma window at exactly five symbols, at six symbols, and with a different phase in between. A design with a wrong window length, or one that does not restart the window on a phase change, misses or adds a reframe there. Finally it drops the enable to check that the run counter really clears.

// File: rtl/comma_framer_pkg.sv
// Shared constants and helpers for the comma framer.
// Assumes a 10-bit line code whose comma has two disparity forms.
package comma_framer_pkg;
    localparam int SYM_W = 10;
    localparam logic [SYM_W-1:0] COMMA_NEG = 10'b0011111010;
    localparam logic [SYM_W-1:0] COMMA_POS = 10'b1100000101;

    typedef enum logic {MODE_SINGLE, MODE_DOUBLE} frame_mode_e;

    // True when the symbol equals either comma form.
    function automatic logic is_comma(input logic [SYM_W-1:0] s);
        return (s == COMMA_NEG) || (s == COMMA_POS);
    endfunction
endpackage

// File: rtl/comma_framer_shifter.sv
// Serial-in shifter with a comma detector on its full contents.
// The oldest bit sits in the MSB. It assumes one valid bit on every clock.
module comma_framer_shifter
    import comma_framer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_in,
    output logic [SYM_W-1:0] sym_o,
    output logic             comma_hit_o
);
    logic [SYM_W-1:0] shreg;

    // Shift one new bit in at the LSB each clock.
    always_ff @(posedge clk) begin
        if (!rst_n) shreg <= '0;
        else        shreg <= {shreg[SYM_W-2:0], bit_in};
    end

    // Compare the shifter against both comma forms after every bit.
    always_comb begin
        sym_o       = shreg;
        comma_hit_o = is_comma(shreg);
    end
endmodule

// File: rtl/comma_framer_bitcnt.sv
// Bit-phase counter that marks symbol boundaries.
// A reframe request restarts it, so the current shifter contents form a boundary.
module comma_framer_bitcnt #(
    parameter int W = 10,
    localparam int CW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reframe_req,
    output logic [CW-1:0] phase_o,
    output logic          aligned_o
);
    logic [CW-1:0] cnt;
    logic          wrap;

    // Detect the last bit of a symbol on the current boundary.
    always_comb begin
        wrap      = (cnt == CW'(W-1));
        aligned_o = wrap || reframe_req;
        phase_o   = cnt;
    end

    // Advance the phase, restarting on a wrap or on a reframe.
    always_ff @(posedge clk) begin
        if (!rst_n)                   cnt <= '0;
        else if (wrap || reframe_req) cnt <= '0;
        else                          cnt <= cnt + CW'(1);
    end
endmodule

// File: rtl/comma_framer_ctrl.sv
// Reframe decision, run-length mode switch, double-comma window and ready hold.
// It assumes that phase_in identifies the bit phase within a symbol and that
// byte_aligned marks every symbol boundary, including reframe boundaries.
module comma_framer_ctrl
    import comma_framer_pkg::*;
#(
    parameter int W         = 10,
    parameter int RUN_LIMIT = 2048,
    parameter int WIN_BYTES = 5,
    localparam int CW       = $clog2(W),
    localparam int RUN_W    = $clog2(RUN_LIMIT + 2),
    localparam int WIN_BITS = WIN_BYTES * W,
    localparam int WT_W     = $clog2(WIN_BITS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reframe_en,
    input  logic          comma_hit,
    input  logic [CW-1:0] phase_in,
    input  logic          byte_aligned,
    output logic          reframe_req,
    output logic          ready_next
);
    logic             en_prev;
    logic             hold;
    logic [RUN_W-1:0] run_cnt;
    logic             win_open;
    logic [CW-1:0]    win_phase;
    logic [WT_W-1:0]  win_timer;
    frame_mode_e      mode;
    logic             en_rise;
    logic             pair_hit;
    logic             hold_next;

    // Decide mode, pair match, reframe and next ready state.
    always_comb begin
        en_rise     = reframe_en && !en_prev;
        mode        = (run_cnt > RUN_W'(RUN_LIMIT)) ? MODE_DOUBLE : MODE_SINGLE;
        pair_hit    = win_open && (phase_in == win_phase);
        reframe_req = reframe_en && comma_hit && ((mode == MODE_SINGLE) || pair_hit);
        hold_next   = (hold || en_rise) && !reframe_req;
        ready_next  = byte_aligned && !hold_next;
    end

    // Track the enable edge and the ready hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_prev <= 1'b0;
            hold    <= 1'b0;
        end else begin
            en_prev <= reframe_en;
            hold    <= hold_next;
        end
    end

    // Count enabled symbols, saturating one past the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)                                           run_cnt <= '0;
        else if (!reframe_en)                                 run_cnt <= '0;
        else if (byte_aligned && run_cnt <= RUN_W'(RUN_LIMIT)) run_cnt <= run_cnt + RUN_W'(1);
    end

    // Open, restart and expire the double-comma window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_open  <= 1'b0;
            win_phase <= '0;
            win_timer <= '0;
        end else if (!reframe_en || mode == MODE_SINGLE || reframe_req) begin
            win_open  <= 1'b0;
        end else if (comma_hit) begin
            win_open  <= 1'b1;
            win_phase <= phase_in;
            win_timer <= WT_W'(WIN_BITS);
        end else if (win_open) begin
            if (win_timer == WT_W'(1)) win_open <= 1'b0;
            win_timer <= win_timer - WT_W'(1);
        end
    end
endmodule

// File: rtl/comma_framer.sv
// Top of the comma framer: shifter, bit counter, control and registered outputs.
// It assumes a continuous serial stream, one bit per clock, with the first bit
// of each symbol sent first.
module comma_framer
    import comma_framer_pkg::*;
#(
    parameter int RUN_LIMIT = 2048,
    parameter int WIN_BYTES = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_in,
    input  logic             reframe_en,
    output logic             byte_strobe,
    output logic [SYM_W-1:0] word_out,
    output logic             ready,
    output logic             reframe_pulse
);
    localparam int CW = $clog2(SYM_W);

    logic [SYM_W-1:0] sym;
    logic             comma_hit;
    logic [CW-1:0]    phase;
    logic             byte_aligned;
    logic             reframe_req;
    logic             ready_next;

    comma_framer_shifter u_shift (
        .clk(clk), .rst_n(rst_n), .bit_in(ser_in),
        .sym_o(sym), .comma_hit_o(comma_hit)
    );

    comma_framer_bitcnt #(.W(SYM_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .reframe_req(reframe_req),
        .phase_o(phase), .aligned_o(byte_aligned)
    );

    comma_framer_ctrl #(.W(SYM_W), .RUN_LIMIT(RUN_LIMIT), .WIN_BYTES(WIN_BYTES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .reframe_en(reframe_en), .comma_hit(comma_hit),
        .phase_in(phase), .byte_aligned(byte_aligned),
        .reframe_req(reframe_req), .ready_next(ready_next)
    );

    // Register the symbol, strobe, ready and reframe outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_strobe   <= 1'b0;
            word_out      <= '0;
            ready         <= 1'b0;
            reframe_pulse <= 1'b0;
        end else begin
            byte_strobe   <= byte_aligned;
            reframe_pulse <= reframe_req;
            ready         <= ready_next;
            if (byte_aligned) word_out <= sym;
        end
    end
endmodule

// File: rtl/comma_framer_chk.sv
// Port-level checker for the comma framer. It keeps its own small models of
// strobe spacing and of the ready hold, and is attached with a bind.
module comma_framer_chk #(
    parameter int W = 10
) (
    input logic         clk,
    input logic         rst_n,
    input logic         reframe_en,
    input logic         byte_strobe,
    input logic [W-1:0] word_out,
    input logic         ready,
    input logic         reframe_pulse
);
    logic       past_ok;
    logic       seen;
    logic [7:0] since;
    logic       en_q;
    logic       gate_raw;

    // Track history: valid past, strobe spacing, enable edge and ready hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            past_ok  <= 1'b0;
            seen     <= 1'b0;
            since    <= '0;
            en_q     <= 1'b0;
            gate_raw <= 1'b0;
        end else begin
            past_ok  <= 1'b1;
            en_q     <= reframe_en;
            gate_raw <= (gate_raw && !reframe_pulse) || (reframe_en && !en_q);
            if (byte_strobe) begin
                seen  <= 1'b1;
                since <= '0;
            end else if (since != 8'hFF) begin
                since <= since + 8'd1;
            end
        end
    end

    // R2
    pulse_has_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reframe_pulse |-> byte_strobe);

    // R5
    ready_has_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> byte_strobe);

    // R3
    no_reframe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && reframe_pulse) |-> $past(reframe_en));

    // R1
    strobe_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_strobe && !reframe_pulse && seen) |-> (since == 8'(W-1)));

    // R1
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !byte_strobe) |-> $stable(word_out));

    // R4
    ready_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_raw && !reframe_pulse) |-> !ready);
endmodule

bind comma_framer comma_framer_chk #(.W(comma_framer_pkg::SYM_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reframe_en(reframe_en), .byte_strobe(byte_strobe),
    .word_out(word_out), .ready(ready), .reframe_pulse(reframe_pulse)
);

// File: tb/comma_framer_tb_top.sv
`timescale 1ns/1ps
module comma_framer_tb_top;
    import comma_framer_pkg::*;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       ser_in = 1'b0;
    logic       reframe_en = 1'b0;
    logic       byte_strobe, ready, reframe_pulse;
    logic [9:0] word_out;

    comma_framer dut_i (
        .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .reframe_en(reframe_en),
        .byte_strobe(byte_strobe), .word_out(word_out), .ready(ready),
        .reframe_pulse(reframe_pulse)
    );

    int errors = 0, checks = 0, bitn = 0;
    logic fill_b = 1'b0;
    bit done = 0;
    int rf_cnt = 0, rf_bitn = 0, rdy_cnt = 0, st_bitn = 0;
    logic [9:0] rf_word = '0, st_word = '0;
    logic rf_ready = 0, st_ready = 0;

    // Vector: {en, polarity, offset[3:0]}
    localparam logic [5:0] VEC [8] = '{6'b1_0_0011, 6'b1_1_0111, 6'b0_0_0101, 6'b1_1_0000,
                                       6'b1_0_1001, 6'b0_1_0010, 6'b1_1_0001, 6'b1_0_0110};

    // Observe outputs away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (byte_strobe) begin st_bitn = bitn; st_word = word_out; st_ready = ready; end
            if (ready) rdy_cnt++;
            if (reframe_pulse) begin
                rf_cnt++; rf_bitn = bitn; rf_word = word_out; rf_ready = ready;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        ser_in = b;
        @(posedge clk);
        #1;
        bitn++;
    endtask

    task automatic send_fill(input int n);
        for (int i = 0; i < n; i++) begin
            send_bit(fill_b);
            fill_b = ~fill_b;
        end
    endtask

    task automatic send_sym(input logic [9:0] s);
        for (int i = 9; i >= 0; i--) send_bit(s[i]);
    endtask

    function automatic bit is_fill(input logic [9:0] w);
        return (w == 10'b0101010101) || (w == 10'b1010101010);
    endfunction

    initial begin
        #(5.0 * 190000);
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog all-R actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int n, rf0, rdy0, st0;
        logic prev_en;
        logic [9:0] code;
        // R11: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(byte_strobe == 0 && ready == 0 && reframe_pulse == 0 && word_out == 0,
            "R11 reset outputs", int'({byte_strobe, ready, reframe_pulse, word_out}), 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        send_fill(4);

        // Table walk: commas at assorted offsets, polarities and enables
        prev_en = 1'b0;
        foreach (VEC[v]) begin
            reframe_en = VEC[v][5];
            code = VEC[v][4] ? COMMA_POS : COMMA_NEG;
            rf0 = rf_cnt; rdy0 = rdy_cnt;
            send_fill(int'(VEC[v][3:0]));
            send_sym(code);
            n = bitn;
            #2;
            if (VEC[v][5] && !prev_en)
                chk(rdy_cnt == rdy0, "R4 ready held before comma", rdy_cnt, rdy0);
            send_fill(30);
            if (VEC[v][5]) begin
                chk(rf_cnt == rf0 + 1, "R2 one reframe", rf_cnt, rf0 + 1);
                chk(rf_bitn == n + 1, "R2 reframe timing", rf_bitn, n + 1);
                chk(rf_word == code, "R2 comma on word_out", int'(rf_word), int'(code));
                chk(rf_ready == 1, "R4 ready on comma strobe", int'(rf_ready), 1);
                chk(st_bitn == n + 21, "R1 strobe every 10 after reframe", st_bitn, n + 21);
                chk(is_fill(st_word), "R1 aligned word content", int'(st_word), 341);
                chk(st_ready == 1, "R5 ready on strobe", int'(st_ready), 1);
            end else begin
                chk(rf_cnt == rf0, "R3 no reframe when disabled", rf_cnt, rf0);
                chk(st_bitn > n + 20, "R3 strobes continue", st_bitn, n + 21);
            end
            prev_en = VEC[v][5];
        end

        // R4: long hold after enable rise, with strobes passing
        reframe_en = 1'b0;
        send_fill(25);
        reframe_en = 1'b1;
        rdy0 = rdy_cnt; st0 = st_bitn;
        send_fill(45);
        #2;
        chk(rdy_cnt == rdy0, "R4 ready low on unaligned strobes", rdy_cnt, rdy0);
        chk(st_bitn > st0, "R4 strobes seen while held", st_bitn, st0 + 10);
        send_sym(COMMA_NEG);
        send_fill(3);
        chk(rf_ready == 1, "R4 ready resumes on comma", int'(rf_ready), 1);

        // R6: still single mode below the run limit
        send_fill(20000);
        rf0 = rf_cnt;
        send_fill(4);
        send_sym(COMMA_POS);
        n = bitn;
        send_fill(6);
        chk(rf_cnt == rf0 + 1 && rf_bitn == n + 1, "R6 single comma below limit", rf_cnt, rf0 + 1);

        // R6/R7: past the limit a single comma is not enough
        send_fill(600);
        rf0 = rf_cnt;
        send_fill(3);
        send_sym(COMMA_NEG);
        send_fill(5);
        chk(rf_cnt == rf0, "R6 double mode after limit", rf_cnt, rf0);
        send_fill(35);
        send_sym(COMMA_POS);
        n = bitn;
        send_fill(4);
        chk(rf_cnt == rf0 + 1 && rf_bitn == n + 1, "R7 pair at 5 symbols reframes", rf_bitn, n + 1);

        // R8: pair 6 symbols apart is outside the window
        send_fill(200);
        rf0 = rf_cnt;
        send_sym(COMMA_NEG);
        send_fill(50);
        send_sym(COMMA_NEG);
        send_fill(3);
        chk(rf_cnt == rf0, "R8 pair beyond window ignored", rf_cnt, rf0);

        // R9: different phase restarts window at its own phase
        send_fill(4);
        send_sym(COMMA_POS);
        send_fill(3);
        chk(rf_cnt == rf0, "R9 other-phase comma no reframe", rf_cnt, rf0);
        send_fill(37);
        send_sym(COMMA_NEG);
        n = bitn;
        send_fill(4);
        chk(rf_cnt == rf0 + 1 && rf_bitn == n + 1, "R9 pair on new phase reframes", rf_bitn, n + 1);

        // R10: dropping enable returns to single mode
        reframe_en = 1'b0;
        send_fill(1);
        reframe_en = 1'b1;
        rf0 = rf_cnt;
        send_fill(5);
        send_sym(COMMA_POS);
        n = bitn;
        send_fill(4);
        chk(rf_cnt == rf0 + 1 && rf_bitn == n + 1, "R10 single mode after enable drop", rf_cnt, rf0 + 1);

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule